// File: doc/BRIEF.md
# Three-Port Control and Status Register Bank

This block holds the control and status registers for three identical line ports plus one global register. Software reaches them over a byte-wide utility bus with separate read and write strobes. The upper address bits pick a port and the lower bits pick one of nine registers within that port. A single global register sits apart from the port banks. Each register is read/write, read-only, write-only or sticky. Sticky event bits collect hardware events and clear when software reads them.

The ports share one cell interface. A port-select input chooses which port's interface-control bits drive it, so those outputs always reflect the selected port's copy. Each port can also raise an interrupt. The enabled requests of all ports combine into one active-low interrupt line.

Top module: `mpsc_regbank`

## Requirements
- R1: Port p (0 to 2), register k (0 to 8), is at address p*0x10+k, and the global register is at 0x40. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`, and it holds until the next read.
- R2: The read/write registers return what was written, with reserved bits forced to zero. The registers are: offset 0 (bit 7 reserved), offset 2 (all 8 bits), offset 3 (bits 7:6 reserved), offset 6 (bits 7:4 reserved), offset 7 (all 8 bits) and offset 8 (all 8 bits).
- R3: Offset 1 holds sticky bits [3:0], each set by the port's bit of `evt_i`. A read returns the bits collected so far and clears them. An event in the same cycle as the clearing read stays set for the next read. Writes to offset 1 are ignored.
- R4: Offset 4 is read-only and returns the port's byte of `stat_i`, and writes to it are ignored. Offset 5 is write-only and reads as 0x00.
- R5: A write to offset 5 of port p places the written byte on `cmd_pulse_o[8p+7:8p]` for exactly the one cycle after the write edge. At all other times that byte is zero.
- R6: After reset, every register is 0x00, `bus_rdata` is 0x00, `irq_n_o` is 1, and `halt_o`, `if_mode_o`, `if_enh_o`, `glob_o` and `cmd_pulse_o` are all zero.
- R7: In offset 0, bit 0 enables the port's interrupt and bit 6 selects error-only mode. Offset 6 holds the mask bits [3:0]. A port requests an interrupt when bit 0 is set and either bit 6 is clear and (sticky AND mask) is nonzero, or bit 6 is set and sticky bit 0 AND mask bit 0 is 1. `irq_n_o` is low exactly when any port requests, and it lags the register state by one clock.
- R8: Reads of unmapped addresses (offsets 9 to 15 of any port, ports 3 and up, and any global address other than 0x40) return 0x00. Writes to them have no effect.
- R9: `if_mode_o` = {offset 0 bit 3, offset 0 bit 2} of the port named by `sel_port_i`, and `if_enh_o` = that port's offset 7. Both update one clock after their inputs change. A select value of 3 or more gives zeros.
- R10: `halt_o[p]` is offset 0 bit 1 of port p and is valid right after the write edge.
- R11: The global register at 0x40 is read/write on all 8 bits and drives `glob_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Utility bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_i | input | 12 | Event inputs, 4 per port, setting sticky bits |
| stat_i | input | 24 | Live status byte per port |
| sel_port_i | input | 2 | Port whose interface controls are active |
| cmd_pulse_o | output | 24 | One-cycle command byte per port |
| halt_o | output | 3 | Per-port transmit halt |
| if_mode_o | output | 2 | Selected port's {parity check, byte mode} |
| if_enh_o | output | 8 | Selected port's enhanced control byte |
| glob_o | output | 8 | Global register value |
| irq_n_o | output | 1 | Combined active-low interrupt |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge, so it sees exactly one rising edge per step. Read data, write effects, `halt_o`, `glob_o` and the command pulse are due one edge after their strobe. The interrupt line is due one edge after the sticky or control register changes, which is two edges after a write or event. The interface outputs are due one edge after a select change and two edges after a write. Each directed check waits exactly that many falling edges before sampling. The same-cycle case of an event and a clearing read is checked over two reads in a row.

// File: rtl/mpsc_rb_pkg.sv
package mpsc_rb_pkg;
  localparam int DW = 8;

  localparam logic [3:0] OFF_CTRL = 4'd0;
  localparam logic [3:0] OFF_EVT  = 4'd1;
  localparam logic [3:0] OFF_DIAG = 4'd2;
  localparam logic [3:0] OFF_LED  = 4'd3;
  localparam logic [3:0] OFF_STAT = 4'd4;
  localparam logic [3:0] OFF_CMD  = 4'd5;
  localparam logic [3:0] OFF_MASK = 4'd6;
  localparam logic [3:0] OFF_ENH  = 4'd7;
  localparam logic [3:0] OFF_REF  = 4'd8;

  // control byte bit positions
  localparam int CB_IRQ_EN  = 0;
  localparam int CB_HALT    = 1;
  localparam int CB_BYTE    = 2;
  localparam int CB_PARITY  = 3;
  localparam int CB_ERRONLY = 6;

  // writable-bit mask per offset; reserved bits are dropped
  function automatic logic [DW-1:0] rw_mask(input logic [3:0] off, input int evt_w);
    case (off)
      OFF_CTRL: rw_mask = 8'h7F;
      OFF_LED:  rw_mask = 8'h3F;
      OFF_MASK: rw_mask = DW'((1 << evt_w) - 1);
      default:  rw_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/mpsc_rb_port.sv
module mpsc_rb_port
  import mpsc_rb_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [3:0]    off,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [EVT_W-1:0] evt,
  input  logic [DW-1:0] stat,
  output logic [DW-1:0] rd_val,
  output logic [1:0]    mode,
  output logic          halt,
  output logic          irq_en,
  output logic [DW-1:0] enh,
  output logic [DW-1:0] cmd,
  output logic          irq_req
);
  logic [DW-1:0]    ctrl_q, diag_q, led_q, mask_q, enh_q, ref_q, cmd_q;
  logic [EVT_W-1:0] sticky_q;
  logic             wr_hit, clr_hit;

  assign wr_hit  = hit && wr;
  assign clr_hit = hit && rd && (off == OFF_EVT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      diag_q   <= '0;
      led_q    <= '0;
      mask_q   <= '0;
      enh_q    <= '0;
      ref_q    <= '0;
      cmd_q    <= '0;
      sticky_q <= '0;
    end else begin
      cmd_q <= '0;
      if (wr_hit) begin
        case (off)
          OFF_CTRL: ctrl_q <= wdata & rw_mask(off, EVT_W);
          OFF_DIAG: diag_q <= wdata & rw_mask(off, EVT_W);
          OFF_LED:  led_q  <= wdata & rw_mask(off, EVT_W);
          OFF_MASK: mask_q <= wdata & rw_mask(off, EVT_W);
          OFF_ENH:  enh_q  <= wdata & rw_mask(off, EVT_W);
          OFF_REF:  ref_q  <= wdata & rw_mask(off, EVT_W);
          OFF_CMD:  cmd_q  <= wdata;
          default: ;
        endcase
      end
      // a new event beats the clearing read
      sticky_q <= clr_hit ? evt : (sticky_q | evt);
    end
  end

  always_comb begin
    case (off)
      OFF_CTRL: rd_val = ctrl_q;
      OFF_EVT:  rd_val = {{(DW-EVT_W){1'b0}}, sticky_q};
      OFF_DIAG: rd_val = diag_q;
      OFF_LED:  rd_val = led_q;
      OFF_STAT: rd_val = stat;
      OFF_MASK: rd_val = mask_q;
      OFF_ENH:  rd_val = enh_q;
      OFF_REF:  rd_val = ref_q;
      default:  rd_val = '0;
    endcase
  end

  logic [EVT_W-1:0] masked;
  assign masked  = sticky_q & mask_q[EVT_W-1:0];
  assign irq_en  = ctrl_q[CB_IRQ_EN];
  assign irq_req = irq_en && (ctrl_q[CB_ERRONLY] ? masked[0] : (|masked));
  assign mode    = {ctrl_q[CB_PARITY], ctrl_q[CB_BYTE]};
  assign halt    = ctrl_q[CB_HALT];
  assign enh     = enh_q;
  assign cmd     = cmd_q;
endmodule

// File: rtl/mpsc_rb_iface_sel.sv
module mpsc_rb_iface_sel
  import mpsc_rb_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int SEL_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic [NPORT*2-1:0]  mode_flat,
  input  logic [NPORT*DW-1:0] enh_flat,
  output logic [1:0]          mode_q,
  output logic [DW-1:0]       enh_q
);
  logic [1:0]    mode_d;
  logic [DW-1:0] enh_d;

  always_comb begin
    mode_d = '0;
    enh_d  = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (int'(sel) == p) begin
        mode_d = mode_flat[p*2 +: 2];
        enh_d  = enh_flat[p*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      enh_q  <= '0;
    end else begin
      mode_q <= mode_d;
      enh_q  <= enh_d;
    end
  end
endmodule

// File: rtl/mpsc_regbank.sv
module mpsc_regbank
  import mpsc_rb_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int NREG  = 9,
  parameter int EVT_W = 4,
  parameter int AW    = 7,
  parameter logic [6:0] GLOB_ADDR = 7'h40,
  localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NPORT*EVT_W-1:0] evt_i,
  input  logic [NPORT*DW-1:0]  stat_i,
  input  logic [SEL_W-1:0]     sel_port_i,
  output logic [NPORT*DW-1:0]  cmd_pulse_o,
  output logic [NPORT-1:0]     halt_o,
  output logic [1:0]           if_mode_o,
  output logic [DW-1:0]        if_enh_o,
  output logic [DW-1:0]        glob_o,
  output logic                 irq_n_o
);
  localparam int PW = AW - 4;

  logic [PW-1:0]       port_idx;
  logic [3:0]          off;
  logic                off_ok, glob_hit;
  logic [NPORT-1:0]    hit, irq_req, irq_en;
  logic [DW-1:0]       rd_val [NPORT];
  logic [NPORT*2-1:0]  mode_flat;
  logic [NPORT*DW-1:0] enh_flat;
  logic [DW-1:0]       rd_sel, glob_q, rdata_q;
  logic                irq_n_q;

  assign port_idx = bus_addr[AW-1:4];
  assign off      = bus_addr[3:0];
  assign off_ok   = (int'(off) < NREG);
  assign glob_hit = (bus_addr == GLOB_ADDR);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign hit[p] = off_ok && (int'(port_idx) == p);
    mpsc_rb_port #(.EVT_W(EVT_W)) u_port (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[p]),
      .off     (off),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .wdata   (bus_wdata),
      .evt     (evt_i[p*EVT_W +: EVT_W]),
      .stat    (stat_i[p*DW +: DW]),
      .rd_val  (rd_val[p]),
      .mode    (mode_flat[p*2 +: 2]),
      .halt    (halt_o[p]),
      .irq_en  (irq_en[p]),
      .enh     (enh_flat[p*DW +: DW]),
      .cmd     (cmd_pulse_o[p*DW +: DW]),
      .irq_req (irq_req[p])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < NPORT; p++)
      if (hit[p]) rd_sel = rd_val[p];
    if (glob_hit) rd_sel = glob_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      glob_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (bus_rd) rdata_q <= rd_sel;
      if (bus_wr && glob_hit) glob_q <= bus_wdata;
      irq_n_q <= ~(|irq_req);
    end
  end

  mpsc_rb_iface_sel #(.NPORT(NPORT), .SEL_W(SEL_W)) u_iface (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel_port_i),
    .mode_flat (mode_flat),
    .enh_flat  (enh_flat),
    .mode_q    (if_mode_o),
    .enh_q     (if_enh_o)
  );

  assign bus_rdata = rdata_q;
  assign glob_o    = glob_q;
  assign irq_n_o   = irq_n_q;
endmodule

// File: rtl/mpsc_regbank_chk.sv
module mpsc_regbank_chk #(
  parameter int NPORT = 3,
  parameter int AW    = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [7:0]         bus_rdata,
  input logic [NPORT*8-1:0] cmd_pulse_o,
  input logic [NPORT-1:0]   irq_en,
  input logic               irq_n_o
);
  logic mapped, wo_addr;
  always_comb begin
    mapped  = (bus_addr == 7'h40) ||
              ((int'(bus_addr[AW-1:4]) < NPORT) && (bus_addr[3:0] <= 4'd8));
    wo_addr = (int'(bus_addr[AW-1:4]) < NPORT) && (bus_addr[3:0] == 4'd5);
  end

  assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == 8'h00));

  assert_wo_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && wo_addr) |=> (bus_rdata == 8'h00));

  assert_rdata_held_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  assert_cmd_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse_o != '0) |-> $past(bus_wr));

  assert_irq_quiet_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> irq_n_o);
endmodule

bind mpsc_regbank mpsc_regbank_chk #(.NPORT(NPORT), .AW(AW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rdata   (bus_rdata),
  .cmd_pulse_o (cmd_pulse_o),
  .irq_en      (irq_en),
  .irq_n_o     (irq_n_o)
);

// File: tb/mpsc_regbank_tb.sv
module mpsc_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [11:0] evt_i = '0;
  logic [23:0] stat_i = '0;
  logic [1:0]  sel_port_i = '0;
  logic [23:0] cmd_pulse_o;
  logic [2:0]  halt_o;
  logic [1:0]  if_mode_o;
  logic [7:0]  if_enh_o, glob_o;
  logic        irq_n_o;

  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  mpsc_regbank dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [11:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  // {write, addr, data, expected}
  localparam int NV = 23;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 7'h00, 8'hFF, 8'h00}, {1'b0, 7'h00, 8'h00, 8'h7F}, // R2 ctrl bit7 reserved
    {1'b1, 7'h13, 8'hFF, 8'h00}, {1'b0, 7'h13, 8'h00, 8'h3F}, // R2 led
    {1'b1, 7'h26, 8'hFF, 8'h00}, {1'b0, 7'h26, 8'h00, 8'h0F}, // R2 mask
    {1'b1, 7'h17, 8'hA5, 8'h00}, {1'b0, 7'h17, 8'h00, 8'hA5}, // R1 port1 decode
    {1'b1, 7'h28, 8'h3C, 8'h00}, {1'b0, 7'h28, 8'h00, 8'h3C}, // R1 port2 last reg
    {1'b1, 7'h02, 8'h81, 8'h00}, {1'b0, 7'h02, 8'h00, 8'h81}, // R2 diag
    {1'b1, 7'h40, 8'h5A, 8'h00}, {1'b0, 7'h40, 8'h00, 8'h5A}, // R11 global
    {1'b1, 7'h09, 8'h77, 8'h00}, {1'b0, 7'h09, 8'h00, 8'h00}, // R8
    {1'b1, 7'h41, 8'h77, 8'h00}, {1'b0, 7'h41, 8'h00, 8'h00}, // R8
    {1'b0, 7'h30, 8'h00, 8'h00},                              // R8 port 3
    {1'b0, 7'h15, 8'h00, 8'h00},                              // R4 write-only
    {1'b0, 7'h11, 8'h00, 8'h00},                              // R3 empty sticky
    {1'b1, 7'h00, 8'h00, 8'h00}, {1'b0, 7'h00, 8'h00, 8'h00}
  };

  initial begin : wd
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk("R6 rdata", bus_rdata, 0);
    chk("R6 irq_n", irq_n_o, 1);
    chk("R6 halt", halt_o, 0);
    chk("R6 iface", {if_mode_o, if_enh_o}, 0);
    chk("R6 glob/cmd", {glob_o, cmd_pulse_o}, 0);
    bus_read(7'h01, rv); chk("R6 sticky", rv, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23]) bus_write(VEC[i][22:16], VEC[i][15:8]);
      else begin
        bus_read(VEC[i][22:16], rv);
        chk($sformatf("R1/R2/R8 vec %0d", i), rv, VEC[i][7:0]);
      end
    end
    chk("R11 glob_o", glob_o, 8'h5A);

    // R10 halt
    bus_write(7'h10, 8'h02);
    chk("R10 halt set", halt_o, 3'b010);
    bus_write(7'h10, 8'h08);
    chk("R10 halt clr", halt_o, 3'b000);

    // R9 shared interface select
    bus_write(7'h00, 8'h04);
    bus_write(7'h07, 8'h11);
    bus_write(7'h17, 8'h22);
    @(negedge clk);
    chk("R9 sel0 mode", if_mode_o, 2'b01);
    chk("R9 sel0 enh", if_enh_o, 8'h11);
    sel_port_i = 2'd1; @(negedge clk);
    chk("R9 sel1 mode", if_mode_o, 2'b10);
    chk("R9 sel1 enh", if_enh_o, 8'h22);
    sel_port_i = 2'd3; @(negedge clk);
    chk("R9 sel3", {if_mode_o, if_enh_o}, 0);

    // R4 read-only status
    stat_i = 24'h009C00;
    bus_read(7'h14, rv); chk("R4 stat", rv, 8'h9C);
    bus_write(7'h14, 8'h00);
    bus_read(7'h14, rv); chk("R4 stat write ignored", rv, 8'h9C);

    // R5 command pulse
    bus_write(7'h25, 8'hB7);
    chk("R5 pulse", cmd_pulse_o, 24'hB70000);
    @(negedge clk);
    chk("R5 pulse gone", cmd_pulse_o, 0);

    // R3 sticky
    pulse_evt(12'h400);
    bus_read(7'h21, rv); chk("R3 collect", rv, 8'h04);
    bus_read(7'h21, rv); chk("R3 cleared", rv, 8'h00);
    pulse_evt(12'h400);
    bus_write(7'h21, 8'h00);
    bus_read(7'h21, rv); chk("R3 write ignored", rv, 8'h04);
    pulse_evt(12'h002);
    @(negedge clk); bus_addr = 7'h01; bus_rd = 1'b1; evt_i = 12'h008;
    @(negedge clk); bus_rd = 1'b0; evt_i = '0;
    chk("R3 read during event", bus_rdata, 8'h02);
    bus_read(7'h01, rv); chk("R3 event kept", rv, 8'h08);
    bus_read(7'h01, rv); chk("R3 empty", rv, 8'h00);

    // R7 interrupt
    bus_write(7'h06, 8'h0F);
    bus_write(7'h00, 8'h01);
    @(negedge clk);
    chk("R7 idle", irq_n_o, 1);
    pulse_evt(12'h004);
    @(negedge clk);
    chk("R7 asserted", irq_n_o, 0);
    bus_write(7'h00, 8'h41);
    @(negedge clk);
    chk("R7 err-only filters", irq_n_o, 1);
    bus_write(7'h00, 8'h01);
    @(negedge clk);
    chk("R7 reasserted", irq_n_o, 0);
    bus_read(7'h01, rv); chk("R7 sticky val", rv, 8'h04);
    @(negedge clk);
    chk("R7 released", irq_n_o, 1);
    bus_write(7'h00, 8'h41);
    pulse_evt(12'h001);
    @(negedge clk);
    chk("R7 err-only fires", irq_n_o, 0);
    bus_read(7'h01, rv);
    @(negedge clk);
    chk("R7 err-only released", irq_n_o, 1);
    bus_write(7'h00, 8'h00);
    pulse_evt(12'h001);
    @(negedge clk);
    chk("R7 disabled", irq_n_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule